// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block holds the two threshold offsets that a FIFO compares against its fill level to raise an almost-empty flag and an almost-full flag, and provides the logic to program and read them. One register holds the empty-side threshold and the other the full-side threshold. Each is `log2(DEPTH)` bits wide: 13 bits for an 8K-deep FIFO and 14 bits for a 16K-deep one. The memory array and the flag comparators sit outside the block. The block takes their thresholds from `empty_ofs` and `full_ofs`, and it passes a memory strobe out when an access is meant for the array.

The programming method is fixed when master reset is asserted. In word mode, the offsets are written from the data bus on write-clock edges. In bit mode, one bit per write-clock edge is clocked into a chain that runs through both registers. Word read-back on the read clock works in both modes. The `sel_mem` input steers every access. When it is low, write and read accesses go to the offset registers, and a one-bit pointer on each side alternates between the empty register and the full register. When it is high, the accesses become memory strobes.

Top module: `fifo_ofs_loader`

## Requirements
- R1: While `mrst` is high, both offsets take 0x07F if `sel_mem` is 0, or 0x3FF if `sel_mem` is 1. Both access pointers clear to the empty register and `dout` clears to 0.
- R2: In word mode, each write-clock edge with `sel_mem`=0 and `wr_n`=0 loads `din[OFS_W-1:0]` into one offset register. The targets alternate: empty first, then full, then empty again.
- R3: Each read-clock edge with `sel_mem`=0 and `rd_n`=0 puts one offset, zero-extended, on `dout`. The sources alternate: empty first, then full. `dout` holds its value between read-backs.
- R4: In bit mode, each write-clock edge with `ser_en`=1 shifts `ser_din` into the chain. After 2·OFS_W edges, the first bit sits at the empty LSB and the last bit at the full MSB.
- R5: `bit_mode` (1 = bit, 0 = word) is captured only while `mrst` is high. Later changes to it have no effect.
- R6: In bit mode, word writes change neither offset.
- R7: In word mode, `ser_en` pulses change neither offset.
- R8: Word read-back works in bit mode as well.
- R9: With `sel_mem`=1, `mem_wr` follows `!wr_n` and `mem_rd` follows `!rd_n`. The offsets and `dout` stay unchanged. With `sel_mem`=0, both strobes stay low.
- R10: When a read-back and a word write hit the same register on the same edge, `dout` gets the value from before the write.
- R11: With `wr_n`=1, `rd_n`=1 and `ser_en`=0, neither the offsets nor `dout` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| bit_mode | input | 1 | Programming method sampled at reset: 1 bit, 0 word |
| sel_mem | input | 1 | 0: accesses target offsets; 1: FIFO memory |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| ser_en | input | 1 | Serial shift enable, active high |
| ser_din | input | 1 | Serial data bit |
| din | input | DATA_W | Parallel data bus |
| dout | output | DATA_W | Offset read-back bus |
| empty_ofs | output | OFS_W | Almost-empty threshold |
| full_ofs | output | OFS_W | Almost-full threshold |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |

## Verification
The bench checks that the pointers wrap from full back to empty. A design whose pointer failed to toggle, or toggled on memory accesses, would read back the wrong register. It shifts distinct bit patterns through the chain, so a chain that shifts the wrong way or loses a bit shows up as swapped or mirrored offsets. It sends a word write while bit mode is latched, and it changes `bit_mode` after reset, which catches a block that reads the mode pin live. It also performs a read and a write to the same register on the same edge, where a forwarding design would return the new value instead of the old one.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic {PROG_WORD = 1'b0, PROG_BIT = 1'b1} prog_mode_e;

   localparam logic [31:0] DEF_OFS_LO = 32'h0000_007F;
   localparam logic [31:0] DEF_OFS_HI = 32'h0000_03FF;

   function automatic logic [31:0] reset_ofs(input logic sel_hi);
      return sel_hi ? DEF_OFS_HI : DEF_OFS_LO;
   endfunction
endpackage

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
   import ofs_pkg::*;
#(
   parameter int OFS_W = 13
) (
   input  logic             wr_clk,
   input  logic             mrst,
   input  logic             bit_mode,
   input  logic             sel_mem,
   input  logic             wr_n,
   input  logic             ser_en,
   input  logic             ser_din,
   input  logic [OFS_W-1:0] din_lo,
   output logic [OFS_W-1:0] empty_ofs,
   output logic [OFS_W-1:0] full_ofs,
   output logic             ser_mode,
   output logic             wptr
);
   localparam int CHAIN_W = 2 * OFS_W;

   prog_mode_e         mode_q;
   logic [OFS_W-1:0]   ofs_q [2];
   logic [CHAIN_W-1:0] chain_cur;
   logic [CHAIN_W-1:0] chain_nxt;
   logic               shift_go;
   logic               word_go;

   always_ff @(posedge wr_clk or posedge mrst) begin
      if (mrst) mode_q <= bit_mode ? PROG_BIT : PROG_WORD;
   end

   assign ser_mode  = (mode_q == PROG_BIT);
   assign shift_go  = ser_mode && ser_en;
   assign word_go   = !ser_mode && !sel_mem && !wr_n;
   assign chain_cur = {ofs_q[1], ofs_q[0]};
   assign chain_nxt = {ser_din, chain_cur[CHAIN_W-1:1]};

   always_ff @(posedge wr_clk or posedge mrst) begin
      if (mrst)         wptr <= 1'b0;
      else if (word_go) wptr <= ~wptr;
   end

   for (genvar g = 0; g < 2; g++) begin : g_ofs
      always_ff @(posedge wr_clk or posedge mrst) begin
         if (mrst)
            ofs_q[g] <= OFS_W'(reset_ofs(sel_mem));
         else if (shift_go)
            ofs_q[g] <= chain_nxt[g*OFS_W +: OFS_W];
         else if (word_go && (wptr == g[0]))
            ofs_q[g] <= din_lo;
      end
   end

   assign empty_ofs = ofs_q[0];
   assign full_ofs  = ofs_q[1];
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side #(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18
) (
   input  logic              rd_clk,
   input  logic              mrst,
   input  logic              sel_mem,
   input  logic              rd_n,
   input  logic [OFS_W-1:0]  empty_ofs,
   input  logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] dout
);
   logic              rptr;
   logic              rd_go;
   logic [OFS_W-1:0]  pick;
   logic [DATA_W-1:0] rd_word;

   assign rd_go = !sel_mem && !rd_n;
   assign pick  = rptr ? full_ofs : empty_ofs;

   if (DATA_W == OFS_W) begin : g_nopad
      assign rd_word = pick;
   end else begin : g_pad
      assign rd_word = {{(DATA_W-OFS_W){1'b0}}, pick};
   end

   always_ff @(posedge rd_clk or posedge mrst) begin
      if (mrst) begin
         rptr <= 1'b0;
         dout <= '0;
      end else if (rd_go) begin
         rptr <= ~rptr;
         dout <= rd_word;
      end
   end
endmodule

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader #(
   parameter int DEPTH  = 8192,
   parameter int DATA_W = 18
) (
   input  logic                       wr_clk,
   input  logic                       rd_clk,
   input  logic                       mrst,
   input  logic                       bit_mode,
   input  logic                       sel_mem,
   input  logic                       wr_n,
   input  logic                       rd_n,
   input  logic                       ser_en,
   input  logic                       ser_din,
   input  logic [DATA_W-1:0]          din,
   output logic [DATA_W-1:0]          dout,
   output logic [$clog2(DEPTH)-1:0]   empty_ofs,
   output logic [$clog2(DEPTH)-1:0]   full_ofs,
   output logic                       mem_wr,
   output logic                       mem_rd
);
   localparam int OFS_W = $clog2(DEPTH);

   if (DEPTH != (1 << OFS_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (OFS_W < 10) begin : g_bad_ofs
      $error("offset width must hold the 0x3FF reset default");
   end
   if (DATA_W < OFS_W) begin : g_bad_data
      $error("DATA_W must be at least the offset width");
   end

   logic ser_mode;
   logic wptr;
   logic [OFS_W-1:0] din_lo;

   assign din_lo = din[OFS_W-1:0];

   if (DATA_W > OFS_W) begin : g_hi
      logic unused_din_hi;
      assign unused_din_hi = ^din[DATA_W-1:OFS_W];
   end

   ofs_wr_side #(.OFS_W(OFS_W)) u_wr (
      .wr_clk    (wr_clk),
      .mrst      (mrst),
      .bit_mode  (bit_mode),
      .sel_mem   (sel_mem),
      .wr_n      (wr_n),
      .ser_en    (ser_en),
      .ser_din   (ser_din),
      .din_lo    (din_lo),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .ser_mode  (ser_mode),
      .wptr      (wptr)
   );

   ofs_rd_side #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
      .rd_clk    (rd_clk),
      .mrst      (mrst),
      .sel_mem   (sel_mem),
      .rd_n      (rd_n),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .dout      (dout)
   );

   assign mem_wr = sel_mem && !wr_n;
   assign mem_rd = sel_mem && !rd_n;
endmodule

// File: rtl/fifo_ofs_loader_chk.sv
module fifo_ofs_loader_chk #(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              mrst,
   input logic              sel_mem,
   input logic              wr_n,
   input logic              rd_n,
   input logic              ser_en,
   input logic [OFS_W-1:0]  din_lo,
   input logic [DATA_W-1:0] dout,
   input logic [OFS_W-1:0]  empty_ofs,
   input logic [OFS_W-1:0]  full_ofs,
   input logic              mem_wr,
   input logic              mem_rd,
   input logic              ser_mode,
   input logic              wptr
);
   // R11
   wr_idle_hold_chk: assert property (@(posedge wr_clk) disable iff (mrst)
      (sel_mem || wr_n) && !ser_en |=> $stable(empty_ofs) && $stable(full_ofs));

   // R6
   bit_mode_no_word_chk: assert property (@(posedge wr_clk) disable iff (mrst)
      ser_mode && !ser_en |=> $stable(empty_ofs) && $stable(full_ofs));

   // R7
   word_mode_no_shift_chk: assert property (@(posedge wr_clk) disable iff (mrst)
      !ser_mode && (sel_mem || wr_n) |=> $stable(empty_ofs) && $stable(full_ofs));

   // R2
   word_wr_empty_chk: assert property (@(posedge wr_clk) disable iff (mrst)
      !ser_mode && !sel_mem && !wr_n && !wptr |=> empty_ofs == $past(din_lo));

   // R9
   rd_hold_chk: assert property (@(posedge rd_clk) disable iff (mrst)
      (sel_mem || rd_n) |=> $stable(dout));

   // R9
   no_strobe_chk: assert property (@(posedge wr_clk) disable iff (mrst)
      !sel_mem |-> !mem_wr && !mem_rd);
endmodule

bind fifo_ofs_loader fifo_ofs_loader_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
   .wr_clk    (wr_clk),
   .rd_clk    (rd_clk),
   .mrst      (mrst),
   .sel_mem   (sel_mem),
   .wr_n      (wr_n),
   .rd_n      (rd_n),
   .ser_en    (ser_en),
   .din_lo    (din_lo),
   .dout      (dout),
   .empty_ofs (empty_ofs),
   .full_ofs  (full_ofs),
   .mem_wr    (mem_wr),
   .mem_rd    (mem_rd),
   .ser_mode  (ser_mode),
   .wptr      (wptr)
);

// File: tb/tb_fifo_ofs_loader.sv
`timescale 1ns/1ps
module tb_fifo_ofs_loader;
   localparam int DEPTH  = 8192;
   localparam int DATA_W = 18;
   localparam int OFS_W  = 13;

   typedef struct packed {
      logic [1:0]  op;    // 0 idle, 1 word write, 2 read-back, 3 memory access
      logic [17:0] data;
      logic [17:0] exp;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{2'd2, 18'h00000, 18'h0007F},  // R1 R3 empty default
      '{2'd2, 18'h00000, 18'h0007F},  // R1 R3 full default
      '{2'd1, 18'h00123, 18'h0007F},  // R2 write empty
      '{2'd1, 18'h3FFFF, 18'h0007F},  // R2 write full, upper bits dropped
      '{2'd2, 18'h00000, 18'h00123},  // R3
      '{2'd2, 18'h00000, 18'h01FFF},  // R3 zero-extended
      '{2'd0, 18'h00000, 18'h01FFF},  // R11 idle
      '{2'd3, 18'h15555, 18'h01FFF},  // R9 memory access
      '{2'd2, 18'h00000, 18'h00123},  // R3 R9 pointer wrap
      '{2'd2, 18'h00000, 18'h01FFF}   // R3
   };

   logic clk = 1'b0;
   logic mrst, bit_mode, sel_mem, wr_n, rd_n, ser_en, ser_din;
   logic [DATA_W-1:0] din, dout;
   logic [OFS_W-1:0]  empty_ofs, full_ofs;
   logic mem_wr, mem_rd;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fifo_ofs_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
      .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .bit_mode(bit_mode),
      .sel_mem(sel_mem), .wr_n(wr_n), .rd_n(rd_n), .ser_en(ser_en),
      .ser_din(ser_din), .din(din), .dout(dout), .empty_ofs(empty_ofs),
      .full_ofs(full_ofs), .mem_wr(mem_wr), .mem_rd(mem_rd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      sel_mem = 1'b0; wr_n = 1'b1; rd_n = 1'b1; ser_en = 1'b0; ser_din = 1'b0;
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic do_reset(input logic ld, input logic meth);
      @(negedge clk);
      idle();
      mrst = 1'b1; sel_mem = ld; bit_mode = meth;
      repeat (2) @(negedge clk);
      mrst = 1'b0;
      idle();
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      mrst = 1'b1; bit_mode = 1'b0; din = '0;
      idle();

      // Table: word mode, low defaults
      do_reset(1'b0, 1'b0);
      chk("R1 empty default low", 32'(empty_ofs), 32'h7F);
      chk("R1 dout reset", 32'(dout), 32'h0);
      foreach (VEC[i]) begin
         din = VEC[i].data;
         case (VEC[i].op)
            2'd1: wr_n = 1'b0;
            2'd2: rd_n = 1'b0;
            2'd3: begin sel_mem = 1'b1; wr_n = 1'b0; rd_n = 1'b0; end
            default: ;
         endcase
         #1;
         if (VEC[i].op == 2'd3) begin
            chk("R9 mem_wr strobe", 32'(mem_wr), 32'h1);
            chk("R9 mem_rd strobe", 32'(mem_rd), 32'h1);
         end
         cycle();
         chk($sformatf("R2/R3/R9/R11 table step %0d", i), 32'(dout), 32'(VEC[i].exp));
      end
      wr_n = 1'b0; #1;
      chk("R9 no strobe with sel_mem low", 32'(mem_wr), 32'h0);
      idle();

      // High defaults, serial ignored in word mode
      do_reset(1'b1, 1'b0);
      chk("R1 empty default high", 32'(empty_ofs), 32'h3FF);
      chk("R1 full default high", 32'(full_ofs), 32'h3FF);
      for (int k = 0; k < 2 * OFS_W; k++) begin
         ser_en = 1'b1; ser_din = 1'b1;
         cycle();
      end
      chk("R7 empty after shifts", 32'(empty_ofs), 32'h3FF);
      chk("R7 full after shifts", 32'(full_ofs), 32'h3FF);

      // Same-edge read and write of the empty register
      do_reset(1'b0, 1'b0);
      din = 18'h00AAA; wr_n = 1'b0; rd_n = 1'b0;
      cycle();
      chk("R10 read returns old value", 32'(dout), 32'h7F);
      rd_n = 1'b0; cycle();
      chk("R10 full still default", 32'(dout), 32'h7F);
      rd_n = 1'b0; cycle();
      chk("R10 new empty value", 32'(dout), 32'hAAA);

      // Bit mode
      do_reset(1'b0, 1'b1);
      bit_mode = 1'b0;
      din = 18'h01111; wr_n = 1'b0;
      cycle();
      chk("R5/R6 word write ignored", 32'(empty_ofs), 32'h7F);
      begin
         logic [2*OFS_W-1:0] pat;
         pat = {13'h0ABC, 13'h1234};
         for (int k = 0; k < 2 * OFS_W; k++) begin
            ser_en = 1'b1; ser_din = pat[k];
            cycle();
         end
      end
      chk("R4 empty from chain", 32'(empty_ofs), 32'h1234);
      chk("R4 full from chain", 32'(full_ofs), 32'h0ABC);
      rd_n = 1'b0; cycle();
      chk("R8 read-back empty", 32'(dout), 32'h1234);
      rd_n = 1'b0; cycle();
      chk("R8 read-back full", 32'(dout), 32'h0ABC);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule